// File: doc/BRIEF.md
# Stereo Audio Control Settings Bank

This block keeps the control state of a two-source stereo audio path and turns it into the step indices and flags that drive the analog switch network downstream. A controller writes one setting per transaction. It presents a function index and an 8-bit value, and pulses a commit strobe for one clock cycle. The commit updates only the register that the index selects.

Each register decodes its value as it is stored:
- Out-of-range volume and tone codes saturate.
- Value bits that a function does not use are dropped.
- Codes reserved for the source and routing functions leave the current setting untouched.

Loudness and stereo enhancement share one register, so a single write always sets both flags. Reset puts the path into a quiet state:
- the source is muted;
- both channels are at maximum attenuation;
- tone is flat;
- the special effects are off.

Volume outputs give the attenuation in 2 dB steps, from 0 (no attenuation) to 40 (-80 dB). Tone outputs give a two's-complement step count from -6 to +6, in 2 dB per step. The serial transport, the analog filters and the gain elements lie outside this block.

Top module: `audio_ctl_regs`

## Requirements
- R1: When synchronous reset is applied, the outputs on the following clock edge are:
  - `src_sel`=0 and `mute`=1;
  - `loud_en`=0 and `enh_en`=0;
  - `bass_step`=0 and `treb_step`=0;
  - `vol_l_att`=40 and `vol_r_att`=40;
  - `route`=01 (stereo).
- R2: A register changes only on a clock edge where `cmt_valid` is high and `fn_idx` selects that register. A commit with `fn_idx`=7 (the read index) changes no output.
- R3: Function index 0 (source) decodes value bits [1:0] as follows:
  - 00 sets `src_sel`=0 and `mute`=0;
  - 01 sets `src_sel`=1 and `mute`=0;
  - 11 sets `mute`=1 and keeps `src_sel`;
  - 10 changes nothing.
- R4: Function index 1 (flags) loads `loud_en` from value bit 0 and `enh_en` from value bit 1 together on every write.
- R5: Function indices 2 (bass) and 3 (treble) take code c = value bits [3:0]. For c from 0 to 11, the output step is c-6. Code 0 gives -6, code 3 gives -3, code 6 gives 0 and code 9 gives +3.
- R6: Tone codes 12 to 15 (binary 11xx) give step +6. Tone value bits [7:4] are ignored.
- R7: Function indices 4 (left volume) and 5 (right volume) take v = value bits [5:0]. The attenuation index is v when v < 40 and 40 otherwise. Bits [7:6] are ignored, and each write touches only its own channel.
- R8: Function index 6 (routing) decodes value bits [2:0] as follows:
  - 100 sets `route`=00 (left mono);
  - 101 sets `route`=01 (stereo);
  - 110 or 111 sets `route`=10 (right mono);
  - 000 to 011 leave `route` unchanged.
  - Bits [7:3] are ignored, and `route` never reads 11.
- R9: A commit is visible on the outputs right after the clock edge that samples the strobe. The outputs do not change before that edge.
- R10: When reset and a commit fall in the same cycle, reset wins and the R1 defaults appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_valid | input | 1 | One-cycle commit strobe |
| fn_idx | input | 3 | Function index of the write |
| fn_val | input | 8 | Value of the write |
| src_sel | output | 1 | Selected source: 0 = input 1, 1 = input 2 |
| mute | output | 1 | Source muted |
| loud_en | output | 1 | Loudness compensation on |
| enh_en | output | 1 | Stereo enhancement on |
| bass_step | output | 4 | Bass step, two's complement, -6..+6 |
| treb_step | output | 4 | Treble step, two's complement, -6..+6 |
| vol_l_att | output | 6 | Left attenuation index, 0..40 |
| vol_r_att | output | 6 | Right attenuation index, 0..40 |
| route | output | 2 | Channel routing: 00 left mono, 01 stereo, 10 right mono |

## Verification
Reset and a commit can fall in the same cycle, and these are the only two functions that can collide, since each commit names exactly one register. The bench first moves the left volume and the mute away from their defaults. It then raises the reset and a commit to the left volume on the same edge, with a value that would clear the attenuation. The outputs are judged to be the reset defaults, with the attenuation at 40. Every other commit is swept across all 256 values of each index, and the full output vector is compared with a model that the bench computes arithmetically.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    ROUTE_LMONO  = 2'd0,
    ROUTE_STEREO = 2'd1,
    ROUTE_RMONO  = 2'd2
  } route_e;

  localparam int FN_SRC   = 0;
  localparam int FN_FLAGS = 1;
  localparam int FN_BASS  = 2;
  localparam int FN_TREB  = 3;
  localparam int FN_VOL_L = 4;
  localparam int FN_VOL_R = 5;
  localparam int FN_MODE  = 6;
  localparam int FN_READ  = 7;
endpackage

// File: rtl/acr_tone_slot.sv
module acr_tone_slot #(
  parameter int FN_W     = 3,
  parameter int VAL_W    = 8,
  parameter int CODE_W   = 4,
  parameter int MAX_STEP = 6,
  parameter int FN_ID    = 2,
  parameter int STEP_W   = $clog2(MAX_STEP + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [FN_W-1:0]          wr_fn,
  input  logic [VAL_W-1:0]         wr_val,
  output logic signed [STEP_W-1:0] step_o
);
  localparam int SPAN = 2 * MAX_STEP;

  logic                     hit;
  logic [CODE_W-1:0]        code;
  logic [CODE_W-1:0]        lim;
  logic signed [CODE_W+1:0] wide;
  logic signed [STEP_W-1:0] step_d;

  assign hit  = wr_en && (wr_fn == FN_W'(FN_ID));
  assign code = wr_val[CODE_W-1:0];

  // Saturate the code at the top of the span, then centre it on flat.
  always_comb begin
    if (int'(code) > SPAN) lim = CODE_W'(SPAN);
    else                   lim = code;
    wide   = $signed({2'b00, lim}) - $signed((CODE_W+2)'(MAX_STEP));
    step_d = wide[STEP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      step_o <= '0;
    else if (hit) step_o <= step_d;
  end

  p_tone_range_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(step_o) >= -MAX_STEP) && (int'(step_o) <= MAX_STEP));

  p_tone_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(step_o));

  p_tone_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && int'(code) >= SPAN) |=> (int'(step_o) == MAX_STEP));
endmodule

// File: rtl/acr_vol_slot.sv
module acr_vol_slot #(
  parameter int FN_W    = 3,
  parameter int VAL_W   = 8,
  parameter int CODE_W  = 6,
  parameter int MAX_ATT = 40,
  parameter int FN_ID   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FN_W-1:0]   wr_fn,
  input  logic [VAL_W-1:0]  wr_val,
  output logic [CODE_W-1:0] att_o
);
  logic              hit;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] att_d;

  assign hit  = wr_en && (wr_fn == FN_W'(FN_ID));
  assign code = wr_val[CODE_W-1:0];

  // Codes at or past the limit all map to full attenuation.
  always_comb begin
    if (int'(code) >= MAX_ATT) att_d = CODE_W'(MAX_ATT);
    else                       att_d = code;
  end

  always_ff @(posedge clk) begin
    if (rst)      att_o <= CODE_W'(MAX_ATT);
    else if (hit) att_o <= att_d;
  end

  p_vol_range_r7: assert property (@(posedge clk) disable iff (rst)
    int'(att_o) <= MAX_ATT);

  p_vol_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(att_o));

  p_vol_rst_r1: assert property (@(posedge clk)
    rst |=> (int'(att_o) == MAX_ATT));
endmodule

// File: rtl/acr_sel_slot.sv
module acr_sel_slot
  import acr_pkg::*;
#(
  parameter int FN_W  = 3,
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [FN_W-1:0]  wr_fn,
  input  logic [VAL_W-1:0] wr_val,
  output logic             src_o,
  output logic             mute_o,
  output logic             loud_o,
  output logic             enh_o,
  output route_e           route_o
);
  logic wr_src, wr_flags, wr_mode;

  assign wr_src   = wr_en && (wr_fn == FN_W'(FN_SRC));
  assign wr_flags = wr_en && (wr_fn == FN_W'(FN_FLAGS));
  assign wr_mode  = wr_en && (wr_fn == FN_W'(FN_MODE));

  // Source selection and mute.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o  <= 1'b0;
      mute_o <= 1'b1;
    end else if (wr_src) begin
      case (wr_val[1:0])
        2'b00:   begin src_o <= 1'b0; mute_o <= 1'b0; end
        2'b01:   begin src_o <= 1'b1; mute_o <= 1'b0; end
        2'b11:   mute_o <= 1'b1;
        default: ;
      endcase
    end
  end

  // Shared register: loudness and enhancement are always loaded together.
  always_ff @(posedge clk) begin
    if (rst) begin
      loud_o <= 1'b0;
      enh_o  <= 1'b0;
    end else if (wr_flags) begin
      loud_o <= wr_val[0];
      enh_o  <= wr_val[1];
    end
  end

  // Channel routing; codes with bit 2 clear are ignored.
  always_ff @(posedge clk) begin
    if (rst) route_o <= ROUTE_STEREO;
    else if (wr_mode && wr_val[2]) begin
      if (wr_val[1])      route_o <= ROUTE_RMONO;
      else if (wr_val[0]) route_o <= ROUTE_STEREO;
      else                route_o <= ROUTE_LMONO;
    end
  end

  p_src_mute_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_src && wr_val[1:0] == 2'b11) |=> (mute_o && $stable(src_o)));

  p_src_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_src && wr_val[1:0] == 2'b10) |=> ($stable(mute_o) && $stable(src_o)));

  p_flags_pair_r4: assert property (@(posedge clk) disable iff (rst)
    wr_flags |=> ((loud_o == $past(wr_val[0])) && (enh_o == $past(wr_val[1]))));

  p_mode_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && !wr_val[2]) |=> $stable(route_o));

  p_route_legal_r8: assert property (@(posedge clk) disable iff (rst)
    route_o != 2'b11);
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
  import acr_pkg::*;
#(
  parameter int FN_W        = 3,
  parameter int VAL_W       = 8,
  parameter int TONE_CODE_W = 4,
  parameter int TONE_MAX    = 6,
  parameter int VOL_CODE_W  = 6,
  parameter int VOL_MAX     = 40,
  localparam int TONE_W     = $clog2(TONE_MAX + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmt_valid,
  input  logic [FN_W-1:0]          fn_idx,
  input  logic [VAL_W-1:0]         fn_val,
  output logic                     src_sel,
  output logic                     mute,
  output logic                     loud_en,
  output logic                     enh_en,
  output logic signed [TONE_W-1:0] bass_step,
  output logic signed [TONE_W-1:0] treb_step,
  output logic [VOL_CODE_W-1:0]    vol_l_att,
  output logic [VOL_CODE_W-1:0]    vol_r_att,
  output logic [1:0]               route
);
  localparam int N_TONE = 2;
  localparam int N_VOL  = 2;

  logic signed [TONE_W-1:0] tone_q [N_TONE];
  logic [VOL_CODE_W-1:0]    vol_q  [N_VOL];
  route_e                   route_q;

  acr_sel_slot #(.FN_W(FN_W), .VAL_W(VAL_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cmt_valid),
    .wr_fn   (fn_idx),
    .wr_val  (fn_val),
    .src_o   (src_sel),
    .mute_o  (mute),
    .loud_o  (loud_en),
    .enh_o   (enh_en),
    .route_o (route_q)
  );

  for (genvar i = 0; i < N_TONE; i++) begin : g_tone
    acr_tone_slot #(
      .FN_W(FN_W), .VAL_W(VAL_W), .CODE_W(TONE_CODE_W),
      .MAX_STEP(TONE_MAX), .FN_ID(FN_BASS + i), .STEP_W(TONE_W)
    ) u_tone (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cmt_valid),
      .wr_fn  (fn_idx),
      .wr_val (fn_val),
      .step_o (tone_q[i])
    );
  end

  for (genvar i = 0; i < N_VOL; i++) begin : g_vol
    acr_vol_slot #(
      .FN_W(FN_W), .VAL_W(VAL_W), .CODE_W(VOL_CODE_W),
      .MAX_ATT(VOL_MAX), .FN_ID(FN_VOL_L + i)
    ) u_vol (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cmt_valid),
      .wr_fn  (fn_idx),
      .wr_val (fn_val),
      .att_o  (vol_q[i])
    );
  end

  assign bass_step = tone_q[0];
  assign treb_step = tone_q[1];
  assign vol_l_att = vol_q[0];
  assign vol_r_att = vol_q[1];
  assign route     = route_q;

  p_read_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && fn_idx == FN_W'(FN_READ)) |=>
      ($stable(src_sel) && $stable(mute) && $stable(loud_en) && $stable(enh_en) &&
       $stable(bass_step) && $stable(treb_step) && $stable(vol_l_att) &&
       $stable(vol_r_att) && $stable(route)));

  // R10: reset wins over a commit in the same cycle.
  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (mute && !src_sel && !loud_en && !enh_en && bass_step == '0 &&
             treb_step == '0 && int'(vol_l_att) == VOL_MAX &&
             int'(vol_r_att) == VOL_MAX && route == 2'b01));
endmodule

// File: tb/audio_ctl_regs_bench.sv
`timescale 1ns/1ps
module audio_ctl_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmt_valid = 1'b0;
  logic [2:0] fn_idx = '0;
  logic [7:0] fn_val = '0;
  logic       src_sel, mute, loud_en, enh_en;
  logic signed [3:0] bass_step, treb_step;
  logic [5:0] vol_l_att, vol_r_att;
  logic [1:0] route;

  int n_chk  = 0;
  int n_fail = 0;

  // Expected state, kept by the bench.
  logic       e_src, e_mute, e_loud, e_enh;
  logic signed [3:0] e_bass, e_treb;
  logic [5:0] e_vl, e_vr;
  logic [1:0] e_route;

  always #2 clk = ~clk;

  audio_ctl_regs u_audio_ctl_regs (
    .clk(clk), .rst(rst), .cmt_valid(cmt_valid), .fn_idx(fn_idx), .fn_val(fn_val),
    .src_sel(src_sel), .mute(mute), .loud_en(loud_en), .enh_en(enh_en),
    .bass_step(bass_step), .treb_step(treb_step), .vol_l_att(vol_l_att),
    .vol_r_att(vol_r_att), .route(route)
  );

  function automatic logic signed [3:0] tone_of(input logic [7:0] v);
    int c = int'(v[3:0]);
    if (c >= 12) return 4'sd6;
    return 4'(c - 6);
  endfunction

  function automatic logic [5:0] vol_of(input logic [7:0] v);
    int c = int'(v[5:0]);
    return (c >= 40) ? 6'd40 : 6'(c);
  endfunction

  task automatic set_defaults();
    e_src = 0; e_mute = 1; e_loud = 0; e_enh = 0;
    e_bass = 0; e_treb = 0; e_vl = 40; e_vr = 40; e_route = 2'b01;
  endtask

  task automatic model(input logic [2:0] f, input logic [7:0] v);
    case (f)
      3'd0: case (v[1:0])
              2'b00: begin e_src = 0; e_mute = 0; end
              2'b01: begin e_src = 1; e_mute = 0; end
              2'b11: e_mute = 1;
              default: ;
            endcase
      3'd1: begin e_loud = v[0]; e_enh = v[1]; end
      3'd2: e_bass = tone_of(v);
      3'd3: e_treb = tone_of(v);
      3'd4: e_vl = vol_of(v);
      3'd5: e_vr = vol_of(v);
      3'd6: if (v[2]) e_route = v[1] ? 2'b10 : (v[0] ? 2'b01 : 2'b00);
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    logic [28:0] act, exp;
    act = {src_sel, mute, loud_en, enh_en, bass_step, treb_step, vol_l_att, vol_r_att, route};
    exp = {e_src, e_mute, e_loud, e_enh, e_bass, e_treb, e_vl, e_vr, e_route};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s fn=%0d val=%02h actual=%08h expected=%08h",
               tag, fn_idx, fn_val, act, exp);
    end
  endtask

  // Inputs change on the falling edge; the rising edge between commits.
  task automatic commit(input logic [2:0] f, input logic [7:0] v);
    @(negedge clk);
    cmt_valid = 1; fn_idx = f; fn_val = v;
    @(negedge clk);
    cmt_valid = 0;
    model(f, v);
  endtask

  function automatic string tag_of(input int f);
    case (f)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5/R6";
      4, 5: return "R7";
      6: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    set_defaults();
    repeat (3) @(negedge clk);
    rst = 0;
    check_all("R1");                 // reset state

    // R9: no visible change before the sampling edge, change right after it
    @(negedge clk);
    cmt_valid = 1; fn_idx = 3'd4; fn_val = 8'd7;
    #1 check_all("R9");
    @(negedge clk);
    cmt_valid = 0; model(3'd4, 8'd7);
    check_all("R9");

    // Sweep every value of every writable function (R3..R8)
    for (int f = 0; f < 7; f++) begin
      for (int v = 0; v < 256; v++) begin
        commit(3'(f), 8'(v));
        check_all(tag_of(f));
      end
    end

    // Spot checks on tone and volume codes named in R5, R6 and R7
    commit(3'd2, 8'h03); check_all("R5");
    commit(3'd3, 8'hF9); check_all("R5");
    commit(3'd2, 8'h3E); check_all("R6");
    commit(3'd4, 8'hD4); check_all("R7");
    commit(3'd5, 8'h2F); check_all("R7");

    // R2: read index changes nothing, for every value
    for (int v = 0; v < 256; v++) begin
      commit(3'd7, 8'(v));
      check_all("R2");
    end

    // R2: no strobe, arbitrary index and value, outputs hold
    @(negedge clk);
    fn_idx = 3'd4; fn_val = 8'h00;
    repeat (4) @(negedge clk);
    check_all("R2");

    // R10: reset and commit collide on one edge
    commit(3'd0, 8'h01);
    commit(3'd4, 8'h05);
    check_all("R10");
    @(negedge clk);
    rst = 1; cmt_valid = 1; fn_idx = 3'd4; fn_val = 8'h00;
    @(negedge clk);
    rst = 0; cmt_valid = 0;
    set_defaults();
    check_all("R10");
    @(negedge clk);
    check_all("R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule